// File: doc/BRIEF.md
# Tick-Gated Button Debouncer

This block turns one bouncing mechanical push-button level into a clean logic level and a small set of single-cycle events. The raw pin is brought into the clock domain through a two-stage synchronizer. It is then looked at only when an internal prescaler issues a one-cycle sample enable, nominally once per millisecond. A 2 to 5 ms sample period also works once the thresholds are scaled to match.

An explicit four-state machine makes every decision: Idle, CandidatePress, Pressed and CandidateRelease. A candidate state is left for its committed state only after the synchronized level has held for a programmable number of consecutive sample ticks. Any earlier flip sends the machine back to the stable state it came from and clears the count. No fixed delay ever blocks the logic, so the block reacts on every clock. A long-hold event sits on top of the Pressed state and fires once per press.

The stability threshold is an 8-bit parameter, and a value of zero behaves as one.

Top module: `btn_debounce`

## Requirements
- R1: A synchronous active-high reset puts the machine in Idle, clears all counters, drives `level` low and holds every event output low.
- R2: The raw input passes through two synchronizer flops and is examined only on the one-cycle tick that the prescaler issues every CLK_PER_TICK clocks. A press is reported between STABLE_TICKS*CLK_PER_TICK+1 and (STABLE_TICKS+1)*CLK_PER_TICK+4 clocks after a clean rising input.
- R3: From CandidatePress, STABLE_TICKS further consecutive high samples commit to Pressed. `press_pulse` is high for exactly one clock in the same cycle that `level` rises.
- R4: If a low sample arrives in CandidatePress before the threshold is met, the machine returns to Idle and no press is reported. `level` stays low.
- R5: From CandidateRelease, STABLE_TICKS further consecutive low samples commit to Idle. `release_pulse` is high for exactly one clock in the same cycle that `level` falls.
- R6: If a high sample arrives in CandidateRelease before the threshold is met, the machine returns to Pressed. No release is reported and `level` stays high.
- R7: `long_pulse` fires for one clock once the button has been held for HOLD_TICKS sample ticks. It fires at most once per press, and the hold count restarts only after a committed release.
- R8: A press released before HOLD_TICKS ticks produces a press event and a release event and no long event.
- R9: At most one of the three event outputs is high in any cycle, and `level` changes only in a cycle that carries the matching press or release event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous button level, high when pressed |
| level | output | 1 | Debounced button level |
| press_pulse | output | 1 | One-clock event on a committed press |
| release_pulse | output | 1 | One-clock event on a committed release |
| long_pulse | output | 1 | One-clock event after a long hold |

## Verification
The bench builds the block with CLK_PER_TICK=4, STABLE_TICKS=3 and HOLD_TICKS=40. At these values a sample tick arrives every four clocks, a commit takes only a handful of ticks, and a long hold fits inside a few hundred clocks. This makes it practical to run glitches that are shorter and longer than the stability window, aborted candidates in both directions, a hold well past the long threshold, a short press, and a reset during a press, all within one short run. Latency is checked against the window implied by the synchronizer, the tick phase and the threshold.

// File: rtl/btn_debounce_pkg.sv
package btn_debounce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CAND_ON  = 2'd1,
        ST_HELD     = 2'd2,
        ST_CAND_OFF = 2'd3
    } db_state_e;

endpackage

// File: rtl/btn_tick_gen.sv
module btn_tick_gen #(
    parameter int CLK_PER_TICK = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CLK_PER_TICK <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLK_PER_TICK);
            localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/btn_db_fsm.sv
module btn_db_fsm
    import btn_debounce_pkg::*;
#(
    parameter logic [7:0] STABLE_TICKS = 8'd20,
    parameter int         HOLD_TICKS   = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic smp,
    output logic level,
    output logic press_pulse,
    output logic release_pulse,
    output logic long_pulse
);
    localparam logic [7:0] N_EFF    = (STABLE_TICKS == 8'd0) ? 8'd1 : STABLE_TICKS;
    localparam logic [8:0] N_CMP    = {1'b0, N_EFF};
    localparam int         HOLD_EFF = (HOLD_TICKS < 1) ? 1 : HOLD_TICKS;
    localparam int         HW       = $clog2(HOLD_EFF + 1);
    localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_EFF);

    typedef struct packed {
        db_state_e     st;
        logic [7:0]    cnt;
        logic [HW-1:0] hold;
        logic          prs;
        logic          rel;
        logic          lng;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [8:0] cnt_inc;

    always_comb begin
        r_d     = r_q;
        r_d.prs = 1'b0;
        r_d.rel = 1'b0;
        r_d.lng = 1'b0;
        cnt_inc = {1'b0, r_q.cnt} + 9'd1;
        if (tick) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (smp) begin
                        r_d.st  = ST_CAND_ON;
                        r_d.cnt = '0;
                    end
                end
                ST_CAND_ON: begin
                    if (!smp) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end else if (cnt_inc == N_CMP) begin
                        r_d.st  = ST_HELD;
                        r_d.cnt = '0;
                        r_d.prs = 1'b1;
                    end else begin
                        r_d.cnt = cnt_inc[7:0];
                    end
                end
                ST_HELD: begin
                    if (!smp) begin
                        r_d.st  = ST_CAND_OFF;
                        r_d.cnt = '0;
                    end else if (r_q.hold != HOLD_MAX) begin
                        r_d.hold = r_q.hold + 1'b1;
                        r_d.lng  = (r_q.hold == HOLD_MAX - 1'b1);
                    end
                end
                ST_CAND_OFF: begin
                    if (smp) begin
                        r_d.st  = ST_HELD;
                        r_d.cnt = '0;
                    end else if (cnt_inc == N_CMP) begin
                        r_d.st   = ST_IDLE;
                        r_d.cnt  = '0;
                        r_d.hold = '0;
                        r_d.rel  = 1'b1;
                    end else begin
                        r_d.cnt = cnt_inc[7:0];
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.hold <= '0;
            r_q.prs  <= 1'b0;
            r_q.rel  <= 1'b0;
            r_q.lng  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign level         = (r_q.st == ST_HELD) || (r_q.st == ST_CAND_OFF);
    assign press_pulse   = r_q.prs;
    assign release_pulse = r_q.rel;
    assign long_pulse    = r_q.lng;
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int         CLK_PER_TICK = 125000,
    parameter logic [7:0] STABLE_TICKS = 8'd20,
    parameter int         HOLD_TICKS   = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic level,
    output logic press_pulse,
    output logic release_pulse,
    output logic long_pulse
);
    logic tick;
    logic smp;

    btn_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    btn_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (btn_raw),
        .dout (smp)
    );

    btn_db_fsm #(
        .STABLE_TICKS (STABLE_TICKS),
        .HOLD_TICKS   (HOLD_TICKS)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .smp           (smp),
        .level         (level),
        .press_pulse   (press_pulse),
        .release_pulse (release_pulse),
        .long_pulse    (long_pulse)
    );
endmodule

// File: rtl/btn_debounce_chk.sv
module btn_debounce_chk (
    input logic clk,
    input logic rst,
    input logic level,
    input logic press_pulse,
    input logic release_pulse,
    input logic long_pulse
);
    logic long_seen_q;

    always_ff @(posedge clk) begin
        if (rst)                long_seen_q <= 1'b0;
        else if (release_pulse) long_seen_q <= 1'b0;
        else if (long_pulse)    long_seen_q <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!level && !press_pulse && !release_pulse && !long_pulse));

    a_r3_press_with_level: assert property (@(posedge clk) disable iff (rst)
        press_pulse |-> level);

    a_r3_press_one_cycle: assert property (@(posedge clk) disable iff (rst)
        press_pulse |=> !press_pulse);

    a_r5_release_with_low: assert property (@(posedge clk) disable iff (rst)
        release_pulse |-> !level);

    a_r5_release_one_cycle: assert property (@(posedge clk) disable iff (rst)
        release_pulse |=> !release_pulse);

    a_r7_long_while_held: assert property (@(posedge clk) disable iff (rst)
        long_pulse |-> level);

    a_r7_long_once: assert property (@(posedge clk) disable iff (rst)
        long_pulse |-> !long_seen_q);

    a_r9_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({press_pulse, release_pulse, long_pulse}));

    a_r9_rise_has_press: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |-> press_pulse);

    a_r9_fall_has_release: assert property (@(posedge clk) disable iff (rst)
        $fell(level) |-> (release_pulse || $past(rst)));
endmodule

bind btn_debounce btn_debounce_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .level         (level),
    .press_pulse   (press_pulse),
    .release_pulse (release_pulse),
    .long_pulse    (long_pulse)
);

// File: tb/btn_debounce_tb.sv
module btn_debounce_tb;
    localparam int         CPT  = 4;
    localparam logic [7:0] NST  = 8'd3;
    localparam int         HOLD = 40;
    localparam int         EV_PRESS = 1, EV_REL = 2, EV_LONG = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_raw = 1'b0;
    logic level, press_pulse, release_pulse, long_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_press_cyc = -1;
    int exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    btn_debounce #(
        .CLK_PER_TICK (CPT),
        .STABLE_TICKS (NST),
        .HOLD_TICKS   (HOLD)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .btn_raw       (btn_raw),
        .level         (level),
        .press_pulse   (press_pulse),
        .release_pulse (release_pulse),
        .long_pulse    (long_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input string req);
        exp_q.push_back(kind);
        tag_q.push_back(req);
    endtask

    task automatic pop_cmp(input int kind);
        if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected event", kind, 0);
        end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(e == kind, t, kind, e);
        end
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (press_pulse) begin
                last_press_cyc = cyc;
                pop_cmp(EV_PRESS);
            end
            if (release_pulse) pop_cmp(EV_REL);
            if (long_pulse)    pop_cmp(EV_LONG);
        end
    end

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        btn_raw = v;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        int t0;
        repeat (10) @(negedge clk);
        check(level == 1'b0, "R1 level in reset", level, 0);
        check({press_pulse, release_pulse, long_pulse} == 3'b0, "R1 events in reset",
              {press_pulse, release_pulse, long_pulse}, 0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 10);

        // R3 / R2: clean press and its latency
        expect_ev(EV_PRESS, "R3 clean press");
        @(negedge clk);
        btn_raw = 1'b1;
        t0 = cyc;
        repeat (39) @(negedge clk);
        check(level == 1'b1, "R3 level after press", level, 1);
        check((last_press_cyc - t0 >= int'(NST) * CPT + 1) &&
              (last_press_cyc - t0 <= (int'(NST) + 1) * CPT + 4),
              "R2 press latency", last_press_cyc - t0, int'(NST) * CPT + 1);

        // R5: clean release
        expect_ev(EV_REL, "R5 clean release");
        drive(1'b0, 40);
        check(level == 1'b0, "R5 level after release", level, 0);

        // R4: glitch shorter than the window
        drive(1'b1, 6);
        drive(1'b0, 40);
        check(level == 1'b0, "R4 level after short glitch", level, 0);

        // R4 then R3: bouncing edge that settles high
        drive(1'b1, 3); drive(1'b0, 3); drive(1'b1, 5); drive(1'b0, 4);
        expect_ev(EV_PRESS, "R3 press after bounce");
        drive(1'b1, 40);
        check(level == 1'b1, "R3 level after bouncing press", level, 1);

        // R6: low glitch while held
        drive(1'b0, 6);
        drive(1'b1, 30);
        check(level == 1'b1, "R6 level after low glitch", level, 1);

        // R7: long hold fires once
        expect_ev(EV_LONG, "R7 long hold");
        drive(1'b1, 200);
        check(exp_q.size() == 0, "R7 long event seen", exp_q.size(), 0);
        drive(1'b1, 200);
        check(level == 1'b1, "R7 still held", level, 1);
        expect_ev(EV_REL, "R5 release after long");
        drive(1'b0, 40);

        // R8: short press, no long
        expect_ev(EV_PRESS, "R8 short press");
        expect_ev(EV_REL, "R8 short release");
        drive(1'b1, 80);
        drive(1'b0, 40);
        check(level == 1'b0, "R8 level after short press", level, 0);

        // R7: hold count restarts after release, long fires again
        expect_ev(EV_PRESS, "R7 second press");
        expect_ev(EV_LONG, "R7 second long");
        drive(1'b1, 250);
        expect_ev(EV_REL, "R7 second release");
        drive(1'b0, 40);

        // R1: reset while held
        expect_ev(EV_PRESS, "R1 press before reset");
        drive(1'b1, 40);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(level == 1'b0, "R1 level after reset while held", level, 0);
        btn_raw = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 20);

        check(exp_q.size() == 0, "R9 all expected events seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule